// File: doc/BRIEF.md
# SMBus Control and Status Register with Interrupt Sequencer

This block is the host-side register for an SMBus master/slave controller. One byte location serves two purposes. A host write loads the control register, which is never readable. A host read returns the status register. The control byte enables the serial interface and the interrupt sources. It also carries start and stop requests and the acknowledge setting to the serial engine. One control bit is a self-clearing command that wipes the pending status.

The status byte gathers flags that the serial engine reports through single-cycle event strobes. These flags are transfer pending, timeout error, stop seen, bus error, last received bit, addressed as slave, lost arbitration and bus busy. While the serial interface is disabled, a read returns the reset pattern instead of the stored flags.

A three-state interrupt sequencer drives the active-low interrupt pin. Its states are:
- `IRQ_IDLE`: no request.
- `IRQ_XFER`: a transfer is pending and interrupts are enabled.
- `IRQ_TMO`: a timeout error is present and both timeout enables are set.

Each cycle, the sequencer takes one transition from any state. Going to IRQ_IDLE has priority; it happens when the interrupt enable is clear or no source is active. Otherwise it goes to IRQ_XFER when the pending flag is active. Otherwise it goes to IRQ_TMO when the timeout error is set and the timeout enable is set. The pin is low in IRQ_XFER and IRQ_TMO.

Top module: `smbcs_regblk`

## Requirements
- R1: After reset, the read data is 0x81, int_n is 1, and req_start, req_stop, ctl_eso and ctl_ack are 0.
- R2: A write loads the control byte with these fields: bit 7 clear-pending, bit 6 serial enable, bit 5 unused, bit 4 timeout-interrupt enable, bit 3 interrupt enable, bit 2 start request, bit 1 stop request, bit 0 acknowledge. The value written never appears on host_rdata. For example, after a write of 0x5F, a read returns the status byte 0x81.
- R3: With the serial enable set, host_rdata returns the status byte with these fields: bit 7 pending (0 = pending), bit 6 timeout error, bit 5 stop seen, bit 4 bus error, bit 3 last received bit, bit 2 addressed as slave, bit 1 lost arbitration, bit 0 bus idle (0 = busy). Each event strobe updates its flag at the next clock edge.
- R4: A write with bit 7 set returns bits 7..1 of the status byte to 1000000 and leaves bit 0 unchanged. The clear bit is not held. A write with bit 7 at 0 leaves every status flag unchanged.
- R5: An event strobe in the same cycle as a clear-pending write wins, so its flag is set after that edge.
- R6: int_n goes to 0 one clock after the pending flag becomes active while the interrupt enable is 1, and returns to 1 one clock after the cause goes away.
- R7: A timeout error drives int_n low only when both the timeout enable and the interrupt enable are 1.
- R8: eng_timeout sets the timeout error flag whatever the value of the timeout enable.
- R9: While the serial enable is 0, host_rdata reads 0x81 whatever the stored flags are.
- R10: req_start and req_stop follow control bits 2 and 1 as levels. Each is cleared by its acknowledge strobe when no write occurs in that cycle.
- R11: eng_busy_set drives status bit 0 to 0 and eng_busy_clr drives it to 1. A clear-pending write leaves the bit alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Write strobe for the control byte |
| host_wdata | input | 8 | Control byte |
| host_rdata | output | 8 | Status byte view |
| int_n | output | 1 | Active-low interrupt |
| ctl_eso | output | 1 | Serial interface enable to engine |
| ctl_ack | output | 1 | Acknowledge setting to engine |
| req_start | output | 1 | Start request level |
| req_stop | output | 1 | Stop request level |
| eng_done | input | 1 | Byte finished: pending flag active |
| eng_timeout | input | 1 | Timeout detected |
| eng_stop | input | 1 | Stop seen on bus |
| eng_berr | input | 1 | Bus error detected |
| eng_aas | input | 1 | Addressed as slave |
| eng_lab | input | 1 | Arbitration lost |
| eng_lrb_load | input | 1 | Load last received bit |
| eng_lrb | input | 1 | Last received bit value |
| eng_busy_set | input | 1 | Bus became busy |
| eng_busy_clr | input | 1 | Bus became idle |
| eng_start_ack | input | 1 | Engine issued the start |
| eng_stop_ack | input | 1 | Engine issued the stop |

## Verification
A corrupted status flag shows on host_rdata at the sample right after the edge that should have set or cleared it, provided the serial enable is set. A wrong sequencer state shows on int_n one cycle later. When the serial enable is clear the flags are masked, so their errors stay hidden until the enable returns. The bench therefore alternates that enable at random. A start or stop request that is not released shows on req_start or req_stop in the cycle after the acknowledge.

// File: rtl/smbcs_pkg.sv
package smbcs_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] STAT_RST = 8'h81;

    // control field positions
    localparam int C_CLRP = 7;
    localparam int C_ESO  = 6;
    localparam int C_TIE  = 4;
    localparam int C_ENI  = 3;
    localparam int C_STA  = 2;
    localparam int C_STO  = 1;
    localparam int C_ACK  = 0;

    // status field positions
    localparam int S_PIN = 7;
    localparam int S_TE  = 6;
    localparam int S_STS = 5;
    localparam int S_BER = 4;
    localparam int S_LRB = 3;
    localparam int S_AAS = 2;
    localparam int S_LAB = 1;
    localparam int S_NBB = 0;

    // sticky flags that only events set and clear-pending clears
    localparam int N_STICKY = 5;
    localparam int STICKY_POS [N_STICKY] = '{S_TE, S_STS, S_BER, S_AAS, S_LAB};

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_XFER = 2'd1,
        IRQ_TMO  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/smbcs_ctl_reg.sv
module smbcs_ctl_reg
    import smbcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              start_ack,
    input  logic              stop_ack,
    output logic              eso,
    output logic              tie,
    output logic              eni,
    output logic              ack,
    output logic              sta,
    output logic              sto,
    output logic              clr_pulse
);
    assign clr_pulse = wr & wdata[C_CLRP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eso <= 1'b0;
            tie <= 1'b0;
            eni <= 1'b0;
            ack <= 1'b0;
            sta <= 1'b0;
            sto <= 1'b0;
        end else if (wr) begin
            eso <= wdata[C_ESO];
            tie <= wdata[C_TIE];
            eni <= wdata[C_ENI];
            ack <= wdata[C_ACK];
            sta <= wdata[C_STA];
            sto <= wdata[C_STO];
        end else begin
            if (start_ack) sta <= 1'b0;
            if (stop_ack)  sto <= 1'b0;
        end
    end
endmodule

// File: rtl/smbcs_stat_reg.sv
module smbcs_stat_reg
    import smbcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_pulse,
    input  logic                done,
    input  logic [N_STICKY-1:0] sticky_set,
    input  logic                lrb_load,
    input  logic                lrb_val,
    input  logic                busy_set,
    input  logic                busy_clr,
    output logic [BYTE_W-1:0]   stat
);
    logic [N_STICKY-1:0] sticky_q;
    logic                pin_q;
    logic                lrb_q;
    logic                nbb_q;

    for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             sticky_q[g] <= 1'b0;
            else if (sticky_set[g]) sticky_q[g] <= 1'b1;
            else if (clr_pulse)     sticky_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
            lrb_q <= 1'b0;
            nbb_q <= 1'b1;
        end else begin
            if (done)           pin_q <= 1'b0;
            else if (clr_pulse) pin_q <= 1'b1;
            if (lrb_load)       lrb_q <= lrb_val;
            else if (clr_pulse) lrb_q <= 1'b0;
            if (busy_set)       nbb_q <= 1'b0;
            else if (busy_clr)  nbb_q <= 1'b1;
        end
    end

    always_comb begin
        stat        = '0;
        stat[S_PIN] = pin_q;
        stat[S_LRB] = lrb_q;
        stat[S_NBB] = nbb_q;
        for (int i = 0; i < N_STICKY; i++) begin
            stat[STICKY_POS[i]] = sticky_q[i];
        end
    end
endmodule

// File: rtl/smbcs_irq_fsm.sv
module smbcs_irq_fsm
    import smbcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eni,
    input  logic tie,
    input  logic pin,
    input  logic te,
    output logic int_n
);
    irq_state_e state_q, state_d;

    always_comb begin
        if (!eni)           state_d = IRQ_IDLE;
        else if (!pin)      state_d = IRQ_XFER;
        else if (tie && te) state_d = IRQ_TMO;
        else                state_d = IRQ_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_IDLE: int_n = 1'b1;
            IRQ_XFER: int_n = 1'b0;
            IRQ_TMO:  int_n = 1'b0;
            default:  int_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/smbcs_regblk.sv
module smbcs_regblk
    import smbcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              int_n,
    output logic              ctl_eso,
    output logic              ctl_ack,
    output logic              req_start,
    output logic              req_stop,
    input  logic              eng_done,
    input  logic              eng_timeout,
    input  logic              eng_stop,
    input  logic              eng_berr,
    input  logic              eng_aas,
    input  logic              eng_lab,
    input  logic              eng_lrb_load,
    input  logic              eng_lrb,
    input  logic              eng_busy_set,
    input  logic              eng_busy_clr,
    input  logic              eng_start_ack,
    input  logic              eng_stop_ack
);
    logic              ctl_tie, ctl_eni, clr_pulse;
    logic [BYTE_W-1:0] stat_q;
    logic [N_STICKY-1:0] sticky_set;
    logic              unused_rsvd;

    assign unused_rsvd = host_wdata[5];

    // order follows STICKY_POS
    assign sticky_set = {eng_lab, eng_aas, eng_berr, eng_stop, eng_timeout};

    smbcs_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (host_wr),
        .wdata     (host_wdata),
        .start_ack (eng_start_ack),
        .stop_ack  (eng_stop_ack),
        .eso       (ctl_eso),
        .tie       (ctl_tie),
        .eni       (ctl_eni),
        .ack       (ctl_ack),
        .sta       (req_start),
        .sto       (req_stop),
        .clr_pulse (clr_pulse)
    );

    smbcs_stat_reg u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_pulse  (clr_pulse),
        .done       (eng_done),
        .sticky_set (sticky_set),
        .lrb_load   (eng_lrb_load),
        .lrb_val    (eng_lrb),
        .busy_set   (eng_busy_set),
        .busy_clr   (eng_busy_clr),
        .stat       (stat_q)
    );

    smbcs_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .eni   (ctl_eni),
        .tie   (ctl_tie),
        .pin   (stat_q[S_PIN]),
        .te    (stat_q[S_TE]),
        .int_n (int_n)
    );

    assign host_rdata = ctl_eso ? stat_q : STAT_RST;
endmodule

// File: rtl/smbcs_regblk_chk.sv
module smbcs_regblk_chk
    import smbcs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [BYTE_W-1:0] host_wdata,
    input logic [BYTE_W-1:0] host_rdata,
    input logic              int_n,
    input logic              ctl_eso,
    input logic              ctl_tie,
    input logic              ctl_eni,
    input logic              req_start,
    input logic              req_stop,
    input logic [BYTE_W-1:0] stat_q,
    input logic              eng_done,
    input logic              eng_timeout,
    input logic              eng_stop,
    input logic              eng_berr,
    input logic              eng_aas,
    input logic              eng_lab,
    input logic              eng_lrb_load,
    input logic              eng_busy_set,
    input logic              eng_busy_clr,
    input logic              eng_start_ack,
    input logic              eng_stop_ack
);
    logic quiet;
    assign quiet = !eng_done && !eng_timeout && !eng_stop && !eng_berr &&
                   !eng_aas && !eng_lab && !eng_lrb_load;

    AST_CLR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_wdata[7] && host_wdata[6] && quiet |=> host_rdata[7:1] == 7'b1000000); // R4
    AST_CLR_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_wdata[7] && !eng_busy_set && !eng_busy_clr |=> stat_q[0] == $past(stat_q[0])); // R11
    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !stat_q[7]); // R5
    AST_TE_ANY_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_timeout |=> stat_q[6]); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> $past(ctl_eni && (!stat_q[7] || (ctl_tie && stat_q[6])))); // R6
    AST_TMO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n && $past(stat_q[7]) |-> $past(ctl_tie && ctl_eni)); // R7
    AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_eso |-> host_rdata == 8'h81); // R9
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_ack && !host_wr |=> !req_start); // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_stop_ack && !host_wr |=> !req_stop); // R10
    AST_BUSY_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy_set |=> !stat_q[0]); // R11
endmodule

bind smbcs_regblk smbcs_regblk_chk chk_i (.*);

// File: tb/smbcs_regblk_tb_top.sv
module smbcs_regblk_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       int_n, ctl_eso, ctl_ack, req_start, req_stop;
    logic       eng_done = 0, eng_timeout = 0, eng_stop = 0, eng_berr = 0;
    logic       eng_aas = 0, eng_lab = 0, eng_lrb_load = 0, eng_lrb = 0;
    logic       eng_busy_set = 0, eng_busy_clr = 0;
    logic       eng_start_ack = 0, eng_stop_ack = 0;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    // reference state
    logic m_eso, m_tie, m_eni, m_ack, m_sta, m_sto;
    logic m_pin, m_te, m_sts, m_ber, m_lrb, m_aas, m_lab, m_nbb;
    logic m_int_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbcs_regblk dut_i (.*);

    function automatic logic [7:0] exp_rdata();
        return m_eso ? {m_pin, m_te, m_sts, m_ber, m_lrb, m_aas, m_lab, m_nbb} : 8'h81;
    endfunction

    function automatic logic exp_int_n();
        return !(m_eni && (!m_pin || (m_tie && m_te)));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        {m_eso, m_tie, m_eni, m_ack, m_sta, m_sto} = '0;
        {m_pin, m_te, m_sts, m_ber, m_lrb, m_aas, m_lab, m_nbb} = 8'h81;
        m_int_n = 1'b1;
    endtask

    task automatic model_edge();
        logic clr;
        clr = host_wr && host_wdata[7];
        m_int_n = exp_int_n();
        if (eng_done) m_pin = 1'b0; else if (clr) m_pin = 1'b1;
        if (eng_timeout) m_te = 1'b1; else if (clr) m_te = 1'b0;
        if (eng_stop) m_sts = 1'b1; else if (clr) m_sts = 1'b0;
        if (eng_berr) m_ber = 1'b1; else if (clr) m_ber = 1'b0;
        if (eng_aas) m_aas = 1'b1; else if (clr) m_aas = 1'b0;
        if (eng_lab) m_lab = 1'b1; else if (clr) m_lab = 1'b0;
        if (eng_lrb_load) m_lrb = eng_lrb; else if (clr) m_lrb = 1'b0;
        if (eng_busy_set) m_nbb = 1'b0; else if (eng_busy_clr) m_nbb = 1'b1;
        if (host_wr) begin
            m_eso = host_wdata[6]; m_tie = host_wdata[4]; m_eni = host_wdata[3];
            m_ack = host_wdata[0]; m_sta = host_wdata[2]; m_sto = host_wdata[1];
        end else begin
            if (eng_start_ack) m_sta = 1'b0;
            if (eng_stop_ack)  m_sto = 1'b0;
        end
    endtask

    task automatic idle_inputs();
        host_wr = 0; host_wdata = '0;
        {eng_done, eng_timeout, eng_stop, eng_berr, eng_aas, eng_lab} = '0;
        {eng_lrb_load, eng_lrb, eng_busy_set, eng_busy_clr} = '0;
        {eng_start_ack, eng_stop_ack} = '0;
    endtask

    // one clock: inputs already driven; compare against model after the edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R3", host_rdata, exp_rdata());
        chk("R6", {7'd0, int_n}, {7'd0, m_int_n});
        chk("R10", {6'd0, req_start, req_stop}, {6'd0, m_sta, m_sto});
        chk("R2", {7'd0, ctl_ack}, {7'd0, m_ack});
        idle_inputs();
    endtask

    task automatic wr(input logic [7:0] d);
        host_wr = 1; host_wdata = d;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done_run) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1", host_rdata, 8'h81);
        chk("R1", {3'd0, int_n, ctl_eso, ctl_ack, req_start, req_stop}, 8'h10);

        // R2 control is write-only
        wr(8'h5F);
        chk("R2", host_rdata, 8'h81);
        chk("R10", {6'd0, req_start, req_stop}, 8'h03);
        eng_start_ack = 1; step();
        chk("R10", {6'd0, req_start, req_stop}, 8'h01);
        eng_stop_ack = 1; step();
        chk("R10", {6'd0, req_start, req_stop}, 8'h00);

        // R3 and R11: status layout
        eng_done = 1; eng_stop = 1; eng_berr = 1; eng_aas = 1; eng_lab = 1;
        eng_lrb_load = 1; eng_lrb = 1; eng_busy_set = 1;
        step();
        chk("R3", host_rdata, 8'h3E);
        chk("R6", {7'd0, int_n}, 8'h01);
        step();
        chk("R6", {7'd0, int_n}, 8'h00);

        // R4 clear-pending keeps bus-busy
        wr(8'hC8);
        chk("R4", host_rdata, 8'h80);
        step();
        chk("R6", {7'd0, int_n}, 8'h01);
        eng_stop = 1; step();
        wr(8'h48);
        chk("R4", host_rdata, 8'hA0);

        // R5 and R8: event wins over clear, TE regardless of TIE
        host_wr = 1; host_wdata = 8'hC8; eng_timeout = 1; step();
        chk("R5", host_rdata, 8'hC0);
        chk("R8", host_rdata & 8'h40, 8'h40);
        step(); step();
        chk("R7", {7'd0, int_n}, 8'h01);
        wr(8'h58);
        step();
        chk("R7", {7'd0, int_n}, 8'h00);
        wr(8'h50);
        step();
        chk("R7", {7'd0, int_n}, 8'h01);

        // R9 masked read
        wr(8'h00);
        chk("R9", host_rdata, 8'h81);

        // R11 busy clear
        eng_busy_clr = 1; step();
        wr(8'h40);
        chk("R11", host_rdata, 8'hC1);

        // constrained random
        for (int n = 0; n < N_RAND; n++) begin
            int pick;
            host_wr = ($urandom_range(0, 3) == 0);
            host_wdata = 8'($urandom);
            if ($urandom_range(0, 3) != 0) host_wdata[6] = 1'b1;
            eng_done     = ($urandom_range(0, 9) == 0);
            eng_timeout  = ($urandom_range(0, 11) == 0);
            eng_stop     = ($urandom_range(0, 9) == 0);
            eng_berr     = ($urandom_range(0, 11) == 0);
            eng_aas      = ($urandom_range(0, 11) == 0);
            eng_lab      = ($urandom_range(0, 11) == 0);
            eng_lrb_load = ($urandom_range(0, 5) == 0);
            eng_lrb      = 1'($urandom);
            pick = $urandom_range(0, 7);
            eng_busy_set = (pick == 0);
            eng_busy_clr = (pick == 1);
            eng_start_ack = ($urandom_range(0, 4) == 0);
            eng_stop_ack  = ($urandom_range(0, 4) == 0);
            step();
        end

        done_run = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule